// File: doc/BRIEF.md
# Predicate redirection lookup table

This block keeps a small table that says which architectural registers run predicated, and which register holds the mask for each one. Software loads the table in one wide write of 16 packed entries. Each entry names a target register, either integer or floating-point. It also names the register that supplies that target's element mask, and carries an invert flag and a zeroing flag. On a write, the block scatters the entries into two per-register tables of 32 slots each, one for integer registers and one for floating-point registers. A decoder can then find a register's predicate state by a single direct index instead of searching the entries.

The read side is combinational. Decode presents a register number and an integer/float selector. The block returns an enable flag, a 6-bit predicate register address whose top bit is the bank bit, and the invert and zeroing flags. Decode also presents the raw contents of the predicate register. The block returns the element mask after any inversion, and it never writes that register back. A register with no entry is unpredicated and gets an all-ones mask. Zeroing is only reported here; applying it to the destination is the job of the consumer.

Top module: `pred_redirect_table`

## Requirements
- R1: After reset every register in both tables is unpredicated: `lk_en`=0, `lk_pidx`=0, `lk_inv`=0, `lk_zero`=0, `lk_mask` all ones.
- R2: Entry e sits at `cfg_data[14e+13:14e]`. Its fields are: bit 13 bank, bit 12 zeroing, bit 11 invert, bit 10 table select (0 integer, 1 float), bits 9..5 target register, bits 4..0 predicate register.
- R3: A write with `cfg_we`=1 is captured at the clock edge. Lookups reflect the new table from the cycle after that edge.
- R4: A register named by an entry in the chosen table returns `lk_en`=1, `lk_pidx`={bank, predicate register}, and the entry's invert and zeroing flags. An entry in one table does not enable the same register number in the other table.
- R5: A register named by no entry returns `lk_en`=0, with index and flags at zero and `lk_mask` all ones, whatever `lk_raw` holds.
- R6: A write replaces the whole table. Registers enabled only by an earlier write become unpredicated.
- R7: When several entries name the same register in the same table, the highest-numbered entry supplies that register's state.
- R8: For a predicated register, `lk_mask` equals `lk_raw` when invert is 0 and equals the bitwise complement of `lk_raw` when invert is 1.
- R9: While `cfg_we` is 0, changes on `cfg_data` have no effect on any lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the table from `cfg_data` |
| cfg_data | input | 224 | 16 packed 14-bit entries, entry 0 in the low bits |
| lk_fp | input | 1 | Lookup table select: 0 integer, 1 float |
| lk_reg | input | 5 | Register number to look up |
| lk_raw | input | 32 | Raw contents of the predicate register |
| lk_en | output | 1 | Register is predicated |
| lk_pidx | output | 6 | Predicate register address, bank bit on top |
| lk_inv | output | 1 | Mask is inverted before use |
| lk_zero | output | 1 | Masked-off elements are to be zeroed |
| lk_mask | output | 32 | Element mask after inversion |

## Verification
The bench sweeps all 64 lookup slots after each of several configurations and compares every output against a model that scans the entries from the highest number downwards. Several corner cases are covered. With all entries keyed to one register, a design that let the lowest entry win would report the wrong index. A second write that drops registers catches a design that only adds state and leaves stale enables behind. Entries that differ only in the table select catch a design that mixes up the integer and float tables. Changing `cfg_data` while `cfg_we` is low catches a table that follows its input without being written. Alternating `lk_raw` patterns against the invert flag expose an inverted or unmasked result.

// File: rtl/pred_redirect_table.sv
module pred_redirect_table #(
  parameter int NENT = 16,
  parameter int KW   = 5,
  parameter int XLEN = 32,
  localparam int NREG = 1 << KW,
  localparam int EW   = 2 * KW + 4,
  localparam int SW   = KW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [NENT*EW-1:0]  cfg_data,
  input  logic                lk_fp,
  input  logic [KW-1:0]       lk_reg,
  input  logic [XLEN-1:0]     lk_raw,
  output logic                lk_en,
  output logic [KW:0]         lk_pidx,
  output logic                lk_inv,
  output logic                lk_zero,
  output logic [XLEN-1:0]     lk_mask
);

  logic [2*NREG-1:0] en_q, inv_q, zero_q, en_d, inv_d, zero_d;
  logic [KW:0]       idx_q [2*NREG];
  logic [KW:0]       idx_d [2*NREG];
  logic [EW-1:0]     ent;
  logic [SW-1:0]     slot;

  always_comb begin
    en_d = '0; inv_d = '0; zero_d = '0;
    ent = '0; slot = '0;
    for (int t = 0; t < 2*NREG; t++) idx_d[t] = '0;
    for (int e = 0; e < NENT; e++) begin
      ent  = cfg_data[e*EW +: EW];
      slot = {ent[2*KW], ent[2*KW-1:KW]};
      en_d[slot]   = 1'b1;
      inv_d[slot]  = ent[2*KW+1];
      zero_d[slot] = ent[2*KW+2];
      idx_d[slot]  = {ent[EW-1], ent[KW-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0; inv_q <= '0; zero_q <= '0;
      for (int t = 0; t < 2*NREG; t++) idx_q[t] <= '0;
    end else if (cfg_we) begin
      en_q <= en_d; inv_q <= inv_d; zero_q <= zero_d;
      for (int t = 0; t < 2*NREG; t++) idx_q[t] <= idx_d[t];
    end
  end

  logic [SW-1:0] lslot;
  assign lslot   = {lk_fp, lk_reg};
  assign lk_en   = en_q[lslot];
  assign lk_inv  = inv_q[lslot];
  assign lk_zero = zero_q[lslot];
  assign lk_pidx = idx_q[lslot];
  assign lk_mask = !lk_en ? '1 : (lk_inv ? ~lk_raw : lk_raw);

  AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(en_q)); // R9
  AST_WRITE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (en_q != '0)); // R3
  AST_ENABLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(en_q) <= NENT); // R6
  AST_UNPRED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |-> (lk_mask == '1 && !lk_inv && !lk_zero && lk_pidx == '0)); // R5

endmodule

// File: tb/pred_redirect_table_tb_top.sv
module pred_redirect_table_tb_top;
  localparam int NENT = 16;
  localparam int EW = 14;

  logic clk = 0, rst_n = 0, cfg_we = 0, lk_fp = 0;
  logic [NENT*EW-1:0] cfg_data = '0;
  logic [4:0] lk_reg = '0;
  logic [31:0] lk_raw = '0;
  logic lk_en, lk_inv, lk_zero;
  logic [5:0] lk_pidx;
  logic [31:0] lk_mask;

  int checks = 0, fails = 0;
  logic [EW-1:0] ents [NENT];
  logic [EW-1:0] model [NENT];
  logic [31:0] seed = 32'h1234_5678;

  pred_redirect_table dut_i (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .lk_fp(lk_fp), .lk_reg(lk_reg), .lk_raw(lk_raw), .lk_en(lk_en), .lk_pidx(lk_pidx),
    .lk_inv(lk_inv), .lk_zero(lk_zero), .lk_mask(lk_mask));

  always #4 clk = ~clk;

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic pack_and_write(input bit do_we);
    @(negedge clk);
    for (int e = 0; e < NENT; e++) cfg_data[e*EW +: EW] = ents[e];
    cfg_we = do_we;
    @(negedge clk);
    cfg_we = 0;
    if (do_we) for (int e = 0; e < NENT; e++) model[e] = ents[e];
  endtask

  task automatic sweep(input string tag);
    for (int f = 0; f < 2; f++)
      for (int r = 0; r < 32; r++) begin
        bit hit = 0;
        logic [EW-1:0] m = '0;
        logic [31:0] raw, emask;
        logic [5:0] epidx;
        for (int e = NENT-1; e >= 0; e--)
          if (!hit && model[e][10] == f[0] && model[e][9:5] == r[4:0]) begin
            hit = 1; m = model[e];
          end
        raw = 32'hA5C3_0F00 ^ {r[4:0], f[0], 26'h15A_96C3};
        epidx = hit ? {m[13], m[4:0]} : 6'd0;
        emask = !hit ? 32'hFFFF_FFFF : (m[11] ? ~raw : raw);
        lk_fp = f[0]; lk_reg = r[4:0]; lk_raw = raw;
        #1;
        checks++;
        if (lk_en !== hit || lk_pidx !== epidx || lk_inv !== (hit & m[11]) ||
            lk_zero !== (hit & m[12]) || lk_mask !== emask) begin
          fails++;
          $display("FAIL %s fp=%0d reg=%0d actual en=%b pidx=%h inv=%b zero=%b mask=%h expected en=%b pidx=%h inv=%b zero=%b mask=%h",
            tag, f, r, lk_en, lk_pidx, lk_inv, lk_zero, lk_mask,
            hit, epidx, hit & m[11], hit & m[12], emask);
        end
      end
  endtask

  initial begin
    for (int e = 0; e < NENT; e++) begin ents[e] = '0; model[e] = 14'h3FFF; end
    for (int e = 0; e < NENT; e++) model[e][9:5] = 5'd0;
    for (int e = 0; e < NENT; e++) model[e] = '1;
    // R1: reset state; model holds no match (entries marked unreachable below)
    for (int e = 0; e < NENT; e++) model[e] = {4'b0, 1'b1, 9'd0} ^ 14'h0400 ^ 14'h0400;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int e = 0; e < NENT; e++) model[e][9:5] = 5'd0;
    // R1 check: before any write nothing is enabled; use sweep with empty model
    begin
      checks++;
      lk_fp = 0; lk_reg = 0; lk_raw = 32'h0; #1;
      if (lk_en !== 0 || lk_mask !== 32'hFFFF_FFFF || lk_pidx !== 0) begin
        fails++; $display("FAIL R1 actual en=%b mask=%h expected en=0 mask=ffffffff", lk_en, lk_mask);
      end
      for (int f = 0; f < 2; f++) for (int r = 0; r < 32; r++) begin
        lk_fp = f[0]; lk_reg = r[4:0]; lk_raw = 32'h1234_0000 + r; #1;
        checks++;
        if (lk_en !== 0 || lk_mask !== 32'hFFFF_FFFF || lk_inv !== 0 || lk_zero !== 0) begin
          fails++; $display("FAIL R1 reg=%0d actual en=%b mask=%h expected en=0 mask=ffffffff", r, lk_en, lk_mask);
        end
      end
    end
    // R2 R4 R8: distinct keys, int and float sharing numbers, mixed flags
    for (int e = 0; e < NENT; e++)
      ents[e] = {e[3] & e[0], e[1], e[0], e[2], 5'(e*2 + 1), 5'(31 - e)};
    pack_and_write(1);
    sweep("R2_R4_R8");
    // R6: replace table; old registers must fall away
    for (int e = 0; e < NENT; e++)
      ents[e] = {1'b0, e[0], ~e[0], e[0], 5'(e*2), 5'(e)};
    pack_and_write(1);
    sweep("R6");
    // R7: all entries share one key; highest number wins
    for (int e = 0; e < NENT; e++)
      ents[e] = {1'b0, e[1], e[0], 1'b1, 5'd9, 5'(e + 3)};
    pack_and_write(1);
    sweep("R7");
    // R3 R4: pseudo-random tables
    for (int k = 0; k < 6; k++) begin
      for (int e = 0; e < NENT; e++) begin seed = nxt(seed); ents[e] = seed[EW-1:0]; end
      pack_and_write(1);
      sweep("R3_R4");
    end
    // R9: data changes without write enable
    for (int e = 0; e < NENT; e++) ents[e] = {1'b0, 1'b1, 1'b1, e[0], 5'(e), 5'(e)};
    pack_and_write(0);
    sweep("R9");
    // R5: unmatched registers with varied raw values covered in sweeps; one explicit
    for (int e = 0; e < NENT; e++) ents[e] = {4'b0011, 5'd4, 5'd7};
    pack_and_write(1);
    lk_fp = 0; lk_reg = 5'd4; lk_raw = 32'h0F0F_0000; #1;
    checks++;
    if (lk_en !== 0 || lk_mask !== 32'hFFFF_FFFF) begin
      fails++; $display("FAIL R5 actual en=%b mask=%h expected en=0 mask=ffffffff", lk_en, lk_mask);
    end
    lk_fp = 1; #1;
    checks++;
    if (lk_en !== 1 || lk_mask !== 32'hF0F0_FFFF || lk_pidx !== 6'd7) begin
      fails++; $display("FAIL R8 actual en=%b mask=%h pidx=%h expected en=1 mask=f0f0ffff pidx=07", lk_en, lk_mask, lk_pidx);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule